// File: doc/BRIEF.md
# MMU Fault Status Capture Unit

This block keeps the record of memory-management faults for a processor. A fault detector elsewhere in the MMU raises a one-cycle report that carries the fault type, a priority level, the access class (instruction fetch or data access), the table level and the faulting address. The unit decides whether the report may replace what is already recorded, keeps a status word and a fault address, and raises a flag when faults of one class pile up before software has looked at them.

Software reads both registers through a small read port. A read of the status word hands back the current contents and then clears the record, so the next fault lands in an empty register. The address register is only ever loaded by data-access faults that win arbitration. Instruction faults leave it untouched.

Top module: `mmu_fault_capture`

## Requirements
- R1: On a synchronous active-high reset the status word, the fault address and the overwrite output are all zero.
- R2: The status word packs valid at bit 0, overwrite at bit 1, access class at bit 2 (1 = instruction), priority at bits 5:3, type at bits 8:6 and level at bits 10:9. A fault reported while valid is 0 is always recorded and sets valid in the next cycle.
- R3: A fault whose 3-bit priority is equal to or larger than the recorded priority replaces the class, priority, type and level fields.
- R4: A fault whose priority is lower than the recorded priority leaves the status word unchanged.
- R5: An accepted data fault loads its address into the fault address register in the next cycle.
- R6: The fault address register keeps its value when an instruction fault arrives or when a fault is rejected.
- R7: The overwrite bit (and the overwrite output) sets when a fault is accepted while a valid record of the same class is held, and stays set until the status word is read. A replacement by a fault of the other class does not set it.
- R8: With rd_sel = 0, rd_data returns the status word zero-extended in the same cycle, and in the next cycle valid, overwrite and priority are zero. With rd_sel = 1, rd_data returns the fault address and nothing is cleared.
- R9: When a status read and a fault report fall in the same cycle, the read returns the old status and the fault is recorded as if the register had been empty, with overwrite 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_vld | input | 1 | One-cycle fault report strobe |
| flt_type | input | 3 | Fault type code |
| flt_prio | input | 3 | Fault priority, larger is higher |
| flt_instr | input | 1 | 1 = instruction fetch, 0 = data access |
| flt_lvl | input | 2 | Table level of the fault |
| flt_addr | input | 32 | Faulting address |
| rd_en | input | 1 | Software read strobe |
| rd_sel | input | 1 | 0 = status word, 1 = fault address |
| rd_data | output | 32 | Read data, valid in the cycle of rd_en |
| fsr_o | output | 11 | Current status word |
| far_o | output | 32 | Current fault address |
| ovw_o | output | 1 | Overwrite indicator |

## Verification
The hardest case to reach is a status read that coincides with a fault report while a record with a set overwrite bit is held, because the stored priority must then be treated as zero and the overwrite must not carry over. Random stimulus draws priorities from a narrow range most of the time so that equal priorities and same-class repeats are frequent, and reads are mixed in at a high rate so that read-plus-fault collisions occur many times. A directed sequence also builds up a set overwrite bit with a top-priority record and then fires a low-priority fault exactly on the read cycle.

// File: rtl/mmu_fault_pkg.sv
package mmu_fault_pkg;
  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_ADDR   = 1'b1
  } rd_sel_e;

  // bit positions of the fixed-width fields in the status word
  localparam int POS_VALID = 0;
  localparam int POS_OVW   = 1;
  localparam int POS_CLS   = 2;
  localparam int POS_PRIO  = 3;
endpackage

// File: rtl/mmu_fault_arb.sv
module mmu_fault_arb #(
  parameter int PRIO_W = 3
) (
  input  logic              flt_vld,
  input  logic [PRIO_W-1:0] flt_prio,
  input  logic              flt_instr,
  input  logic              clr,
  input  logic              cur_valid,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic              cur_cls,
  output logic              accept,
  output logic              ovw_hit
);
  // a new fault wins unless the held one is valid and strictly higher
  function automatic logic may_replace(input logic held,
                                       input logic [PRIO_W-1:0] p_new,
                                       input logic [PRIO_W-1:0] p_old);
    return !held || (p_new >= p_old);
  endfunction

  logic              eff_valid;
  logic [PRIO_W-1:0] eff_prio;

  assign eff_valid = cur_valid && !clr;
  assign eff_prio  = clr ? '0 : cur_prio;
  assign accept    = flt_vld && may_replace(eff_valid, flt_prio, eff_prio);
  assign ovw_hit   = accept && eff_valid && (cur_cls == flt_instr);
endmodule

// File: rtl/mmu_fault_status_reg.sv
module mmu_fault_status_reg #(
  parameter int TYPE_W = 3,
  parameter int PRIO_W = 3,
  parameter int LVL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flt_vld,
  input  logic              clr,
  input  logic              accept,
  input  logic              ovw_hit,
  input  logic [TYPE_W-1:0] flt_type,
  input  logic [PRIO_W-1:0] flt_prio,
  input  logic              flt_instr,
  input  logic [LVL_W-1:0]  flt_lvl,
  output logic              valid_q,
  output logic              ovw_q,
  output logic              cls_q,
  output logic [PRIO_W-1:0] prio_q,
  output logic [TYPE_W-1:0] type_q,
  output logic [LVL_W-1:0]  lvl_q
);
  logic ovw_keep;
  assign ovw_keep = ovw_q && !clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      ovw_q   <= 1'b0;
      cls_q   <= 1'b0;
      prio_q  <= '0;
      type_q  <= '0;
      lvl_q   <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      ovw_q   <= ovw_keep || ovw_hit;
      cls_q   <= flt_instr;
      prio_q  <= flt_prio;
      type_q  <= flt_type;
      lvl_q   <= flt_lvl;
    end else if (clr) begin
      valid_q <= 1'b0;
      ovw_q   <= 1'b0;
      prio_q  <= '0;
    end
  end

  // R4
  low_prio_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (flt_vld && valid_q && !clr && (flt_prio < prio_q))
      |=> ($stable(prio_q) && $stable(type_q) && $stable(cls_q) && $stable(lvl_q)));

  // R8
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !flt_vld) |=> (!valid_q && !ovw_q && (prio_q == '0)));

  // R7
  ovw_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !$rose(ovw_q));

  // R2
  empty_takes_any_chk: assert property (@(posedge clk) disable iff (rst)
    (flt_vld && !valid_q) |=> (valid_q && (prio_q == $past(flt_prio))));
endmodule

// File: rtl/mmu_fault_addr_reg.sv
module mmu_fault_addr_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flt_vld,
  input  logic              flt_instr,
  input  logic              accept,
  input  logic [ADDR_W-1:0] flt_addr,
  output logic [ADDR_W-1:0] far_q
);
  logic load;
  assign load = accept && !flt_instr;

  always_ff @(posedge clk) begin
    if (rst)       far_q <= '0;
    else if (load) far_q <= flt_addr;
  end

  // R6
  instr_no_far_chk: assert property (@(posedge clk) disable iff (rst)
    (flt_vld && flt_instr) |=> $stable(far_q));

  // R6
  reject_no_far_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(far_q));

  // R5
  data_loads_far_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !flt_instr) |=> (far_q == $past(flt_addr)));
endmodule

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture #(
  parameter int TYPE_W = 3,
  parameter int PRIO_W = 3,
  parameter int LVL_W  = 2,
  parameter int ADDR_W = 32,
  localparam int STAT_W = 3 + PRIO_W + TYPE_W + LVL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flt_vld,
  input  logic [TYPE_W-1:0] flt_type,
  input  logic [PRIO_W-1:0] flt_prio,
  input  logic              flt_instr,
  input  logic [LVL_W-1:0]  flt_lvl,
  input  logic [ADDR_W-1:0] flt_addr,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic [ADDR_W-1:0] rd_data,
  output logic [STAT_W-1:0] fsr_o,
  output logic [ADDR_W-1:0] far_o,
  output logic              ovw_o
);
  import mmu_fault_pkg::*;

  logic              clr, accept, ovw_hit;
  logic              valid_q, ovw_q, cls_q;
  logic [PRIO_W-1:0] prio_q;
  logic [TYPE_W-1:0] type_q;
  logic [LVL_W-1:0]  lvl_q;

  assign clr = rd_en && (rd_sel == SEL_STATUS);

  mmu_fault_arb #(.PRIO_W(PRIO_W)) u_arb (
    .flt_vld(flt_vld), .flt_prio(flt_prio), .flt_instr(flt_instr), .clr(clr),
    .cur_valid(valid_q), .cur_prio(prio_q), .cur_cls(cls_q),
    .accept(accept), .ovw_hit(ovw_hit)
  );

  mmu_fault_status_reg #(.TYPE_W(TYPE_W), .PRIO_W(PRIO_W), .LVL_W(LVL_W)) u_fsr (
    .clk(clk), .rst(rst), .flt_vld(flt_vld), .clr(clr), .accept(accept),
    .ovw_hit(ovw_hit), .flt_type(flt_type), .flt_prio(flt_prio),
    .flt_instr(flt_instr), .flt_lvl(flt_lvl), .valid_q(valid_q), .ovw_q(ovw_q),
    .cls_q(cls_q), .prio_q(prio_q), .type_q(type_q), .lvl_q(lvl_q)
  );

  mmu_fault_addr_reg #(.ADDR_W(ADDR_W)) u_far (
    .clk(clk), .rst(rst), .flt_vld(flt_vld), .flt_instr(flt_instr),
    .accept(accept), .flt_addr(flt_addr), .far_q(far_o)
  );

  assign fsr_o   = {lvl_q, type_q, prio_q, cls_q, ovw_q, valid_q};
  assign ovw_o   = ovw_q;
  assign rd_data = (rd_sel == SEL_STATUS) ? {{(ADDR_W-STAT_W){1'b0}}, fsr_o} : far_o;

  // R9
  read_collide_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && flt_vld) |=> (valid_q && !ovw_q));

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> ((fsr_o == '0) && (far_o == '0) && !ovw_o));
endmodule

// File: tb/mmu_fault_capture_test.sv
module mmu_fault_capture_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flt_vld = 1'b0, flt_instr = 1'b0, rd_en = 1'b0, rd_sel = 1'b0;
  logic [2:0]  flt_type = '0, flt_prio = '0;
  logic [1:0]  flt_lvl = '0;
  logic [31:0] flt_addr = '0, rd_data;
  logic [10:0] fsr_o;
  logic [31:0] far_o;
  logic        ovw_o;

  int checks = 0, errors = 0;

  // bench model of the record
  logic       mv = 0, mo = 0, mc = 0;
  logic [2:0] mp = 0, mt = 0;
  logic [1:0] ml = 0;
  logic [31:0] mfar = 0;

  always #10 clk = ~clk;

  mmu_fault_capture uut (
    .clk(clk), .rst(rst), .flt_vld(flt_vld), .flt_type(flt_type),
    .flt_prio(flt_prio), .flt_instr(flt_instr), .flt_lvl(flt_lvl),
    .flt_addr(flt_addr), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .fsr_o(fsr_o), .far_o(far_o), .ovw_o(ovw_o)
  );

  function automatic logic [10:0] pack_status();
    logic [10:0] s;
    s = '0;
    s[0] = mv; s[1] = mo; s[2] = mc;
    s[5:3] = mp; s[8:6] = mt; s[10:9] = ml;
    return s;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_edge(input logic v, input logic [2:0] p, input logic i,
                            input logic [2:0] t, input logic [1:0] l,
                            input logic [31:0] a, input logic re, input logic rs);
    logic clr, ev, eo, acc;
    logic [2:0] ep;
    clr = re && !rs;
    ev  = mv && !clr;
    ep  = clr ? 3'd0 : mp;
    eo  = clr ? 1'b0 : mo;
    acc = v && (!ev || p >= ep);
    if (acc) begin
      mo = eo || (ev && (mc == i));
      mv = 1; mc = i; mp = p; mt = t; ml = l;
      if (!i) mfar = a;
    end else if (clr) begin
      mv = 0; mo = 0; mp = 0;
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [2:0] p,
                      input logic i, input logic [2:0] t, input logic [1:0] l,
                      input logic [31:0] a, input logic re, input logic rs);
    flt_vld = v; flt_prio = p; flt_instr = i; flt_type = t; flt_lvl = l;
    flt_addr = a; rd_en = re; rd_sel = rs;
    #1;
    if (re && !rs) chk({tag, " R8 status read data"}, rd_data, {21'd0, pack_status()});
    if (re && rs)  chk({tag, " R8 address read data"}, rd_data, mfar);
    @(posedge clk);
    model_edge(v, p, i, t, l, a, re, rs);
    @(negedge clk);
    flt_vld = 0; rd_en = 0;
    chk({tag, " status"}, {21'd0, fsr_o}, {21'd0, pack_status()});
    chk({tag, " address"}, far_o, mfar);
    chk({tag, " overwrite"}, {31'd0, ovw_o}, {31'd0, mo});
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 status", {21'd0, fsr_o}, 32'd0);
    chk("R1 address", far_o, 32'd0);
    chk("R1 overwrite", {31'd0, ovw_o}, 32'd0);

    // R2 empty accepts; layout literal: lvl1 type5 prio2 data valid
    step("R2", 1, 3'd2, 0, 3'd5, 2'd1, 32'hA000_0010, 0, 0);
    chk("R2 layout", {21'd0, fsr_o}, {21'd0, 11'b01_101_010_0_0_1});
    chk("R5 load", far_o, 32'hA000_0010);
    // R4 lower priority rejected; R6 far kept
    step("R4", 1, 3'd1, 0, 3'd7, 2'd3, 32'hB000_0020, 0, 0);
    chk("R6 rejected keeps far", far_o, 32'hA000_0010);
    // R3 equal priority replaces, same class -> R7 overwrite
    step("R3", 1, 3'd2, 0, 3'd3, 2'd2, 32'hC000_0030, 0, 0);
    chk("R7 overwrite set", {31'd0, ovw_o}, 32'd1);
    // R6 instruction fault higher priority, far unchanged
    step("R6", 1, 3'd6, 1, 3'd1, 2'd0, 32'hD000_0040, 0, 0);
    chk("R6 instr keeps far", far_o, 32'hC000_0030);
    // R8 address read does not clear
    step("R8 addr", 0, 0, 0, 0, 0, 0, 1, 1);
    chk("R8 no clear", {31'd0, fsr_o[0]}, 32'd1);
    // R8 status read clears
    step("R8 stat", 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R8 cleared", {26'd0, fsr_o[5:0] & 6'b111011}, 32'd0);
    // R7 other class replacement does not set overwrite
    step("R7a", 1, 3'd3, 1, 3'd2, 2'd1, 32'h0, 0, 0);
    step("R7b", 1, 3'd4, 0, 3'd2, 2'd1, 32'hE000_0050, 0, 0);
    chk("R7 cross class", {31'd0, ovw_o}, 32'd0);
    // R9 build overwrite at prio 7, then low-priority fault on the read cycle
    step("R9a", 1, 3'd7, 0, 3'd6, 2'd2, 32'hF000_0060, 0, 0);
    chk("R9 setup ovw", {31'd0, ovw_o}, 32'd1);
    step("R9b", 1, 3'd0, 0, 3'd1, 2'd3, 32'h1111_2222, 1, 0);
    chk("R9 recorded", {21'd0, fsr_o}, {21'd0, 11'b11_001_000_0_0_1});
    chk("R9 far", far_o, 32'h1111_2222);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] p;
      p = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'($urandom_range(2, 3));
      step("R3 R4 R7 random", ($urandom_range(0, 1) == 1), p, 1'($urandom),
           3'($urandom), 2'($urandom), $urandom,
           ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule